// File: doc/BRIEF.md
# Flash Protected-Range Checker

This block screens every flash cycle before it reaches the serial flash engine. Six programmable range registers each describe a span of flash in 4 KiB pages, with a read-protect enable and a write-protect enable. The command issue logic presents a request: the kind of cycle, the start address and the byte count. The checker works out which bytes the cycle would touch and compares that span against every range in parallel. It then returns a verdict. An allowed cycle gets a start pulse. A refused cycle gets an access-error pulse instead, and the controller reports the error and done without the cycle ever reaching the bus.

The range registers are loaded through a single-word write port. A lock input freezes them. Erase cycles are checked as writes over the whole aligned erase block, not just over the given address.

The controller is a three-state machine:
- `ST_IDLE` takes a request and moves to `ST_CHECK` (transition "accept").
- `ST_CHECK` registers the comparison result and moves to `ST_REPORT` (transition "decide").
- `ST_REPORT` presents the one-cycle verdict and returns to `ST_IDLE` (transition "release").

Top module: `flash_range_guard`

## Requirements
- R1: There are six range registers, selected by `cfg_idx` values 0 to 5. A write with `cfg_idx` of 6 or 7 changes no range.
- R2: Each register word has these fields. Bits [13:0] hold the base page and bits [29:16] the limit page. Bit 31 enables write protection and bit 15 enables read protection. A page is 4 KiB. The protected bytes run from base*4096 up to limit*4096+4095, with both ends included.
- R3: A read (`req_kind`=0) covers bytes `req_addr` to `req_addr+req_len`. It is refused exactly when one of those bytes lies in a range that has read protection enabled. A range with only write protection never refuses a read.
- R4: A write (`req_kind`=1) is checked over the same byte span, but only against ranges with write protection enabled. A range with only read protection never refuses a write.
- R5: A small erase (`req_kind`=2) is checked as a write over the whole 4 KiB-aligned block that holds `req_addr`. A large erase (`req_kind`=3) is checked the same way over the whole 64 KiB-aligned block. `req_len` is ignored for erases.
- R6: Some ranges never refuse a cycle: one with both enables clear, and one whose base page is above its limit page.
- R7: While `lock` is high, writes on the configuration port change no range.
- R8: A request is accepted only while `busy` is low. Its verdict appears on `verdict_valid` for exactly one cycle, two clock edges after acceptance. `req_valid` is ignored while `busy` is high.
- R9: With each verdict, exactly one of two things happens. Either `fwd_go` pulses and `block` goes low, or `acc_err` pulses and `block` goes high. `block` holds its value until the next verdict.
- R10: After reset, all ranges are inactive, the machine is idle, and `busy`, `verdict_valid`, `block`, `acc_err` and `fwd_go` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock | input | 1 | Freezes the range registers while high |
| cfg_we | input | 1 | Range register write strobe |
| cfg_idx | input | 3 | Range register select |
| cfg_wdata | input | 32 | Range register word (fields per R2) |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 2 | 0 read, 1 write, 2 small erase, 3 large erase |
| req_addr | input | AW (26) | Flash byte address |
| req_len | input | LW (6) | Byte count minus one |
| busy | output | 1 | A request is being checked |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| block | output | 1 | Last verdict refused the cycle |
| acc_err | output | 1 | Access-error pulse for a refused cycle |
| fwd_go | output | 1 | Start pulse for an allowed cycle |

## Verification
The bench builds the block with its default parameters: six ranges, a 26-bit address and a 6-bit length, so a request spans at most 64 bytes. Random range pages and request addresses are drawn from the first 64 pages. With such small numbers, overlaps, edge-touching spans and inverted (base above limit) ranges all turn up often, and a 64 KiB erase covers sixteen candidate pages at once. Directed cases add byte-exact tests at the page boundaries, the two erase sizes, out-of-range indices, the lock, and a request arriving while the checker is busy.

// File: rtl/frg_pkg.sv
package frg_pkg;
    localparam int FIELD_W   = 14;
    localparam int PG_LG2    = 12;
    localparam int SMALL_LG2 = 12;
    localparam int LARGE_LG2 = 16;
    localparam int CW        = FIELD_W + 2;
    localparam int WP_BIT    = 31;
    localparam int RP_BIT    = 15;
    localparam int LIMIT_LSB = 16;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_ERASE_S = 2'd2,
        OP_ERASE_L = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_REPORT = 2'd2
    } guard_state_t;

    typedef struct packed {
        logic               wp;
        logic               rp;
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] limit;
    } range_t;

    localparam int RANGE_W = $bits(range_t);
endpackage

// File: rtl/frg_span.sv
module frg_span
    import frg_pkg::*;
#(
    parameter int AW = 26,
    parameter int LW = 6
) (
    input  op_kind_t         kind,
    input  logic [AW-1:0]    addr,
    input  logic [LW-1:0]    len,
    output logic [CW-1:0]    first_pg,
    output logic [CW-1:0]    last_pg,
    output logic             is_read
);
    localparam logic [AW:0] S_MASK = (AW+1)'((1 << SMALL_LG2) - 1);
    localparam logic [AW:0] L_MASK = (AW+1)'((1 << LARGE_LG2) - 1);

    logic [AW:0] lo;
    logic [AW:0] hi;

    always_comb begin
        unique case (kind)
            OP_ERASE_S: begin
                lo = {1'b0, addr} & ~S_MASK;
                hi = lo | S_MASK;
            end
            OP_ERASE_L: begin
                lo = {1'b0, addr} & ~L_MASK;
                hi = lo | L_MASK;
            end
            default: begin
                lo = {1'b0, addr};
                hi = {1'b0, addr} + (AW+1)'(len);
            end
        endcase
    end

    assign first_pg = CW'(lo >> PG_LG2);
    assign last_pg  = CW'(hi >> PG_LG2);
    assign is_read  = (kind == OP_READ);
endmodule

// File: rtl/frg_cmp.sv
module frg_cmp
    import frg_pkg::*;
(
    input  range_t           rng,
    input  logic [CW-1:0]    first_pg,
    input  logic [CW-1:0]    last_pg,
    input  logic             is_read,
    output logic             hit
);
    logic          armed;
    logic [CW-1:0] b_pg;
    logic [CW-1:0] l_pg;

    assign b_pg  = CW'(rng.base);
    assign l_pg  = CW'(rng.limit);
    assign armed = is_read ? rng.rp : rng.wp;
    assign hit   = armed && (b_pg <= l_pg) && (first_pg <= l_pg) && (last_pg >= b_pg);
endmodule

// File: rtl/frg_regs.sv
module frg_regs
    import frg_pkg::*;
#(
    parameter int NR = 6,
    localparam int IW = (NR > 1) ? $clog2(NR + 1) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock,
    input  logic                 we,
    input  logic [IW-1:0]        idx,
    input  logic [31:0]          wdata,
    output range_t [NR-1:0]      ranges
);
    range_t dec;
    logic   unused_bits;

    assign dec.wp    = wdata[WP_BIT];
    assign dec.rp    = wdata[RP_BIT];
    assign dec.base  = wdata[FIELD_W-1:0];
    assign dec.limit = wdata[LIMIT_LSB +: FIELD_W];
    assign unused_bits = ^{wdata[30], wdata[14]};

    for (genvar g = 0; g < NR; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ranges[g] <= '0;
            end else if (we && !lock && (idx == IW'(g))) begin
                ranges[g] <= dec;
            end
        end
    end
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
    import frg_pkg::*;
#(
    parameter int NR = 6,
    parameter int AW = 26,
    parameter int LW = 6,
    localparam int IW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock,
    input  logic            cfg_we,
    input  logic [IW-1:0]   cfg_idx,
    input  logic [31:0]     cfg_wdata,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic [AW-1:0]   req_addr,
    input  logic [LW-1:0]   req_len,
    output logic            busy,
    output logic            verdict_valid,
    output logic            block,
    output logic            acc_err,
    output logic            fwd_go
);
    guard_state_t          state_q;
    guard_state_t          state_d;
    range_t [NR-1:0]       ranges_q;
    op_kind_t              kind_q;
    logic [AW-1:0]         addr_q;
    logic [LW-1:0]         len_q;
    logic [CW-1:0]         first_pg;
    logic [CW-1:0]         last_pg;
    logic                  is_read;
    logic [NR-1:0]         hit_vec;
    logic                  any_hit;

    frg_regs #(.NR(NR)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock   (lock),
        .we     (cfg_we),
        .idx    (cfg_idx),
        .wdata  (cfg_wdata),
        .ranges (ranges_q)
    );

    // request capture on the accept transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= OP_READ;
            addr_q <= '0;
            len_q  <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            kind_q <= op_kind_t'(req_kind);
            addr_q <= req_addr;
            len_q  <= req_len;
        end
    end

    frg_span #(.AW(AW), .LW(LW)) u_span (
        .kind     (kind_q),
        .addr     (addr_q),
        .len      (len_q),
        .first_pg (first_pg),
        .last_pg  (last_pg),
        .is_read  (is_read)
    );

    for (genvar r = 0; r < NR; r++) begin : g_cmp
        frg_cmp u_cmp (
            .rng      (ranges_q[r]),
            .first_pg (first_pg),
            .last_pg  (last_pg),
            .is_read  (is_read),
            .hit      (hit_vec[r])
        );
    end

    assign any_hit = |hit_vec;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_CHECK;
            ST_CHECK:  state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_valid <= 1'b0;
            block         <= 1'b0;
            acc_err       <= 1'b0;
            fwd_go        <= 1'b0;
        end else begin
            verdict_valid <= (state_q == ST_CHECK);
            acc_err       <= (state_q == ST_CHECK) && any_hit;
            fwd_go        <= (state_q == ST_CHECK) && !any_hit;
            if (state_q == ST_CHECK) block <= any_hit;
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/flash_range_guard_sva.sv
module flash_range_guard_sva
    import frg_pkg::*;
#(
    parameter int NR = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock,
    input  logic                    cfg_we,
    input  logic                    req_valid,
    input  logic                    busy,
    input  logic                    verdict_valid,
    input  logic                    block,
    input  logic                    acc_err,
    input  logic                    fwd_go,
    input  logic [NR*RANGE_W-1:0]   ranges_flat
);
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> (fwd_go ^ acc_err));

    a_r9_go_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_go |-> !block);

    a_r9_err_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> block);

    a_r9_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_valid |-> $stable(block));

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> ##1 verdict_valid);

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    a_r8_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> busy);

    a_r7_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && cfg_we) |=> $stable(ranges_flat));
endmodule

bind flash_range_guard flash_range_guard_sva #(.NR(NR)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .lock          (lock),
    .cfg_we        (cfg_we),
    .req_valid     (req_valid),
    .busy          (busy),
    .verdict_valid (verdict_valid),
    .block         (block),
    .acc_err       (acc_err),
    .fwd_go        (fwd_go),
    .ranges_flat   (ranges_q)
);

// File: tb/flash_range_guard_bench.sv
`timescale 1ns/1ps
module flash_range_guard_bench;
    localparam int NR = 6;
    localparam int AW = 26;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          busy, verdict_valid, block, acc_err, fwd_go;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit m_wp [NR];
    bit m_rp [NR];
    int m_base [NR];
    int m_lim [NR];

    always #10 clk = ~clk;

    flash_range_guard #(.NR(NR), .AW(AW), .LW(LW)) u_flash_range_guard (
        .clk(clk), .rst_n(rst_n), .lock(lock), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
        .busy(busy), .verdict_valid(verdict_valid), .block(block),
        .acc_err(acc_err), .fwd_go(fwd_go)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_block(input int k, input longint a, input int l);
        longint lo, hi;
        if (k == 2) begin lo = a & ~longint'(32'hFFF);  hi = lo | 32'hFFF;  end
        else if (k == 3) begin lo = a & ~longint'(32'hFFFF); hi = lo | 32'hFFFF; end
        else begin lo = a; hi = a + l; end
        for (int r = 0; r < NR; r++) begin
            bit en = (k == 0) ? m_rp[r] : m_wp[r];
            if (en && m_base[r] <= m_lim[r] &&
                (lo >> 12) <= m_lim[r] && (hi >> 12) >= m_base[r]) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic cfg_write(input int idx, input bit wp, input bit rp, input int b, input int lim);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_idx = 3'(idx);
        cfg_wdata = {wp, 1'b0, 14'(lim), rp, 1'b0, 14'(b)};
        @(negedge clk);
        cfg_we = 1'b0;
        if (!lock && idx < NR) begin
            m_wp[idx] = wp; m_rp[idx] = rp; m_base[idx] = b; m_lim[idx] = lim;
        end
    endtask

    task automatic do_req(input int k, input int a, input int l, input string tag);
        bit e;
        e = exp_block(k, a, l);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(k); req_addr = AW'(a); req_len = LW'(l);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(verdict_valid == 1'b1, {tag, " verdict_valid"}, int'(verdict_valid), 1);
        check(block == e, {tag, " block"}, int'(block), int'(e));
        check(acc_err == e && fwd_go == !e, {tag, " acc_err/fwd_go"},
              int'({acc_err, fwd_go}), int'({e, !e}));
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd97531));
        for (int r = 0; r < NR; r++) begin
            m_wp[r] = 0; m_rp[r] = 0; m_base[r] = 0; m_lim[r] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(busy == 0 && verdict_valid == 0, "R10 idle after reset", int'({busy, verdict_valid}), 0);
        check(block == 0 && acc_err == 0 && fwd_go == 0, "R10 outputs low", int'({block, acc_err, fwd_go}), 0);
        do_req(1, 0, 63, "R10 empty ranges allow write");

        // R2/R3 read protection, byte-exact edges
        cfg_write(0, 0, 1, 2, 3);
        do_req(0, 32'h1FFC, 3, "R3 read just below");
        do_req(0, 32'h1FFC, 4, "R3 read touching base");
        do_req(0, 32'h3FFF, 0, "R2 inclusive limit byte");
        do_req(0, 32'h4000, 0, "R2 first byte past limit");
        do_req(1, 32'h2000, 8, "R4 read-only range passes write");

        // R4/R5 write protection and erase spans
        cfg_write(5, 1, 0, 16, 16);
        do_req(1, 32'h10FFF, 0, "R4 write blocked");
        do_req(0, 32'h10000, 0, "R3 write-only range passes read");
        do_req(2, 32'h11000, 5, "R5 small erase next block");
        do_req(2, 32'h10800, 0, "R5 small erase inside");
        do_req(3, 32'h1F000, 0, "R5 large erase covers page");
        do_req(3, 32'h20000, 0, "R5 large erase next block");

        // R6 inactive ranges
        cfg_write(1, 1, 1, 8, 7);
        do_req(0, 32'h7FFF, 1, "R6 base above limit");
        cfg_write(2, 0, 0, 0, 16383);
        do_req(1, 32'h30000, 0, "R6 both enables clear");

        // R1 out-of-range index
        cfg_write(6, 1, 1, 0, 16383);
        cfg_write(7, 1, 1, 0, 16383);
        do_req(0, 32'h100000, 0, "R1 index 6/7 ignored");

        // R7 lock
        lock = 1'b1;
        cfg_write(3, 1, 1, 0, 16383);
        do_req(0, 32'h100000, 0, "R7 locked write ignored");
        lock = 1'b0;
        cfg_write(3, 1, 1, 0, 16383);
        do_req(0, 32'h100000, 0, "R7 unlocked write lands");
        cfg_write(3, 0, 0, 0, 0);

        // R8 request while busy
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_addr = AW'(32'h50000); req_len = '0;
        @(negedge clk);
        req_kind = 2'd1; req_addr = AW'(32'h10000);
        check(verdict_valid == 0 && busy == 1, "R8 no strobe in check", int'({verdict_valid, busy}), 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(verdict_valid == 1 && fwd_go == 1, "R8 first request verdict", int'({verdict_valid, fwd_go}), 3);
        @(negedge clk);
        check(busy == 0 && verdict_valid == 0, "R8 busy request dropped", int'({busy, verdict_valid}), 0);
        @(negedge clk);
        check(verdict_valid == 0 && block == 0, "R8 R9 block held", int'({verdict_valid, block}), 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 4 == 0) begin
                lock = ($urandom % 5 == 0);
                cfg_write($urandom % 8, 1'($urandom), 1'($urandom), $urandom % 64, $urandom % 64);
                lock = 1'b0;
            end
            do_req($urandom % 4, $urandom % (1 << 18), $urandom % 64, "R3 R4 R5 R9 random");
        end

        done = 1'b1;
        finish_run();
    end
endmodule